// File: doc/BRIEF.md
# Double-Buffered Runt-Free PWM Generator

This block drives one pulse-width-modulated output from a width value that arrives with no fixed relation to the PWM period. The width passes through two holding registers. A staging register captures `width_i` when the load strobe rises. An active register takes a copy of the staging register only at the boundary between two periods. Because of this, a period always uses one width from its first clock to its last, and no shortened or split pulse can appear when new data arrives in the middle of a period.

A free-running counter divides time into periods of 2^CNT_W clocks, which is 4096 at the default width. The output goes high on the first clock of a period and stays high for exactly as many clocks as the active width, then stays low until the period ends. Any correction or scaling of the width takes place upstream of this block.

Top module: `pwm_runtfree_gen`

## Requirements
- R1: While `rst_n` is low, `pwm_o` is low. Reset clears the staging register, the active register and the period counter, so the whole first period after reset is low.
- R2: The staging register captures `width_i` only on a clock edge where `load_i` is sampled high after being sampled low on the edge before. Holding `load_i` high does not capture again, even if `width_i` changes.
- R3: The active width changes only at the boundary between periods. A load made partway through a period does not alter the pulse in that period.
- R4: In every period, `pwm_o` is high on the first N clocks and low on the rest, where N is the active width. The high time is one unbroken run that starts at the first clock of the period.
- R5: A period lasts 2^CNT_W clocks (4096 at the default). A width of 0 keeps the output low for the whole period. A width of 4095 keeps it high on every clock except the last.
- R6: When several loads occur in one period, the period that follows uses only the last value captured before the boundary.
- R7: A rising load sampled on the last clock edge of a period, which is the same edge as the transfer, does not reach the next period. It takes effect in the period after that.
- R8: When there is no new load, the active width stays the same from one period to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM clock; one count per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load strobe; a rising level captures `width_i` |
| width_i | input | CNT_W | Requested high time in clocks |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Loads are placed at three kinds of point. Early and mid-period loads show whether the current pulse is left alone (R3) and whether the last of several writes wins (R6). Loads one clock before the boundary and exactly on it show which side of the transfer edge each one lands on (R7). The widths 0, 1, 3, 4095 and a case with no load at all check the extremes of the comparison and how the value is kept (R5, R8). A load held high while `width_i` changes separates capture on the rising edge from capture on the level (R2).

// File: rtl/pwm_rf_pkg.sv
// Package: shared constants for the runt-free PWM generator.
// Assumes: nothing; holds only the default counter width.
package pwm_rf_pkg;
    localparam int unsigned DEF_CNT_W = 12;
endpackage

// File: rtl/pwm_period_ctr.sv
// Module: pwm_period_ctr
// Free-running period counter of CNT_W bits. It wraps from all-ones to zero,
// so a period is 2**CNT_W clocks. It presents the current count, the count
// for the next clock, and a flag that is set on the last slot of a period.
// Assumes: synchronous active-low reset; counts on every clock edge.
module pwm_period_ctr #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             last_slot
);
    localparam logic [CNT_W-1:0] LAST = '1;

    // Next count: the natural wrap of an unsigned add
    always_comb begin
        cnt_d     = cnt_q + 1'b1;
        last_slot = (cnt_q == LAST);
    end

    // Count register: cleared by reset, advances every clock
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwm_width_buffer.sv
// Module: pwm_width_buffer
// Two-stage width buffer. The staging register captures width_i on a rising
// load strobe. The active register copies the staging register only on the
// edge that ends a period (last_slot high). The next active value is also
// presented so that the output stage can apply it on the first clock of the
// new period.
// Assumes: load_i is synchronous to clk; reset clears both stages.
module pwm_width_buffer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic             last_slot,
    output logic [CNT_W-1:0] staged_q,
    output logic [CNT_W-1:0] active_q,
    output logic [CNT_W-1:0] active_d
);
    logic load_prev;
    logic load_rise;

    // Rising-level detect on the load strobe
    always_comb load_rise = load_i && !load_prev;

    // Remember the load level from the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) load_prev <= 1'b0;
        else        load_prev <= load_i;
    end

    // Stage one: take the new width on a rising load
    always_ff @(posedge clk) begin
        if (!rst_n)         staged_q <= '0;
        else if (load_rise) staged_q <= width_i;
    end

    // Next active width: move it forward only at the period boundary
    always_comb active_d = last_slot ? staged_q : active_q;

    // Stage two: the width in use for the whole current period
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= '0;
        else        active_q <= active_d;
    end
endmodule

// File: rtl/pwm_out_stage.sv
// Module: pwm_out_stage
// Registered comparator. It drives the output high for the slots whose index
// is below the active width. It compares the next count with the next active
// width, so the flop holds the value for the slot the counter is entering.
// Assumes: cnt_d and active_d are the values that will be registered on the
// same edge.
module pwm_out_stage #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [CNT_W-1:0] active_d,
    output logic             pwm_q
);
    logic pwm_d;

    // High while the slot being entered is below the width
    always_comb pwm_d = (cnt_d < active_d);

    // Output flop: glitch-free, low in reset
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end
endmodule

// File: rtl/pwm_runtfree_gen.sv
// Module: pwm_runtfree_gen (top)
// Single-channel PWM generator with a double-buffered width, so every period
// runs with one fixed width and no runt pulse can occur. This module joins the
// period counter, the width buffer and the output stage.
// Assumes: one clock domain; synchronous active-low reset.
module pwm_runtfree_gen #(
    parameter int unsigned CNT_W = pwm_rf_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             last_slot;
    logic [CNT_W-1:0] staged_q;
    logic [CNT_W-1:0] active_q;
    logic [CNT_W-1:0] active_d;

    pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .last_slot (last_slot)
    );

    pwm_width_buffer #(.CNT_W(CNT_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .width_i   (width_i),
        .last_slot (last_slot),
        .staged_q  (staged_q),
        .active_q  (active_q),
        .active_d  (active_d)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_d    (cnt_d),
        .active_d (active_d),
        .pwm_q    (pwm_o)
    );
endmodule

// File: rtl/pwm_runtfree_gen_chk.sv
// Module: pwm_runtfree_gen_chk
// Property checker for pwm_runtfree_gen, attached through bind. It watches
// the ports together with the counter and the two buffer stages.
// Assumes: load_i is low while reset is held.
module pwm_runtfree_gen_chk #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             pwm_o,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] staged,
    input logic [CNT_W-1:0] active
);
    localparam logic [CNT_W-1:0] LAST = '1;

    AST_STAGE_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(load_i) |=> $stable(staged)); // R2

    AST_ACTIVE_HOLDS_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(active)); // R3

    AST_NO_LATE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o && cnt != '0) |-> $past(pwm_o)); // R4

    AST_PERIOD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (pwm_o == (active != '0))); // R4

    AST_LAST_SLOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |-> !pwm_o); // R5

    AST_COUNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0)); // R5
endmodule

bind pwm_runtfree_gen pwm_runtfree_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .pwm_o  (pwm_o),
    .cnt    (cnt_q),
    .staged (staged_q),
    .active (active_q)
);

// File: tb/pwm_runtfree_gen_test.sv
// Scoreboard bench: driver tasks push the width expected in each period, and
// a monitor measures every period at the output and pops the expectation.
module pwm_runtfree_gen_test;
    localparam int CW     = 12;
    localparam int PERIOD = 1 << CW;
    localparam int LASTS  = PERIOD - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [CW-1:0] width_i = '0;
    logic          pwm_o;

    int n_checks = 0;
    int n_fail   = 0;
    int bslot    = 0;
    int periods_done = 0;
    logic [CW-1:0] exp_q[$];
    logic [CW-1:0] staged = '0;

    pwm_runtfree_gen #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .width_i(width_i), .pwm_o(pwm_o)
    );

    always #2 clk = ~clk; // 250 MHz

    // Slot index from the requirements: the period restarts every PERIOD clocks after reset
    always @(posedge clk) begin
        if (!rst_n) bslot <= 0;
        else        bslot <= (bslot + 1) % PERIOD;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: measure the high count and the shape of each period
    int  hi = 0;
    bit  seen_low = 0;
    bit  split = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pwm_o) begin
                hi++;
                if (seen_low) split = 1;
            end else seen_low = 1;
            if (bslot == LASTS) begin
                if (exp_q.size() == 0) check(0, "R4 queue empty", hi, -1);
                else begin
                    automatic int e = int'(exp_q.pop_front());
                    // R3 R5 R6 R7 R8: high count matches the width staged before the boundary
                    check(hi == e, $sformatf("R4 width period %0d", periods_done), hi, e);
                end
                check(!split, $sformatf("R4 single run period %0d", periods_done), int'(split), 0);
                hi = 0; seen_low = 0; split = 0;
                periods_done++;
            end
        end
    end

    // Driver: one rising load at slot s; it is captured on the edge that leaves s
    task automatic load_at(input int s, input logic [CW-1:0] v);
        do @(negedge clk); while (bslot != s);
        width_i = v; load_i = 1'b1;
        staged  = v;
        @(posedge clk); #1 load_i = 1'b0;
    endtask

    // Driver: load held high while width_i changes; only the first value counts (R2)
    task automatic load_held(input int s, input logic [CW-1:0] v1, input logic [CW-1:0] v2);
        do @(negedge clk); while (bslot != s);
        width_i = v1; load_i = 1'b1;
        staged  = v1;
        @(negedge clk); width_i = v2;
        repeat (3) @(negedge clk);
        @(posedge clk); #1 load_i = 1'b0;
    endtask

    // Driver: close the period, pushing what the boundary transfers
    task automatic close_period();
        do @(negedge clk); while (bslot != LASTS);
        exp_q.push_back(staged);
    endtask

    // Driver: load on the transfer edge itself (R7); the boundary keeps the old value
    task automatic load_on_boundary(input logic [CW-1:0] v);
        do @(negedge clk); while (bslot != LASTS);
        exp_q.push_back(staged);
        width_i = v; load_i = 1'b1;
        staged  = v;
        @(posedge clk); #1 load_i = 1'b0;
    endtask

    initial begin
        exp_q.push_back('0); // R1: period 0 after reset is low
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0, "R1 output low in reset", int'(pwm_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        // P0: one early load
        load_at(100, 12'd1200);        close_period();
        // P1: three loads, the last one wins (R6); P1 itself still at 1200 (R3)
        load_at(5, 12'd80);
        load_at(2000, 12'd2730);
        load_at(3000, 12'd40);          close_period();
        // P2: width zero (R5)
        load_at(10, 12'd0);             close_period();
        // P3: largest width (R5)
        load_at(50, 12'd4095);          close_period();
        // P4: no load, value kept (R8)
        close_period();
        // P5: held strobe (R2)
        load_held(200, 12'd3, 12'd999); close_period();
        // P6: load on the transfer edge (R7)
        load_on_boundary(12'd119);
        // P7: nothing new, P8 shows the late load
        close_period();
        // P8: load one slot before the boundary still makes it
        load_at(LASTS - 1, 12'd1);      close_period();
        // P9: keep
        close_period();
        wait (periods_done == 11);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(pwm_o == 1'b0, "R1 output low after reset mid-run", int'(pwm_o), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", periods_done, 11);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule